// File: doc/BRIEF.md
# Delta-Sigma ADC Channel Scan Sequencer

This block runs a delta-sigma converter through a list of differential input pairs over a four-wire serial link. It waits for the converter's active-low data-ready line to fall. It then opens a frame and reprograms the converter's input selector for the next list entry. Next it restarts the conversion with a synchronise command followed by a wake-up command, and only then reads the 24-bit result that was already pending. Because the selector changes before the read, each result belongs to the entry that was selected one step earlier. The block tags each result with that entry's index.

The channel list is a flat table input of up to eight selector bytes. Each byte holds the positive input index in its high nibble and the negative input index in its low nibble. A length input sets how many entries are in use. The serial clock is a parameterised division of the system clock. The minimum command gaps and the wait before the result read are parameters counted in serial-clock periods.

Top module: `adc_scan_seq`

## Requirements
- R1: Each fall of `drdy_n_i` seen while no frame is open produces exactly one frame. In that frame `cs_n_o` goes low, exactly 6 command bytes and 24 result bits are clocked, and `cs_n_o` then goes high in the same cycle that `res_valid_o` pulses high for one cycle.
- R2: The command bytes on `din_o` come in this fixed order: selector write opcode 0x51 (0x50 ORed with selector address 1), count byte 0x00, selector byte, synchronise 0xFC, wake-up 0x00, read-data 0x01. Each byte is sent MSB first.
- R3: The selector byte written in a frame is table entry `list_tbl_i[8*k +: 8]`, where k is the list index after the current one.
- R4: The 24 result bits are assembled MSB first into `res_data_o`. `res_tag_o` carries the list index that was current before the frame, which is the entry the converter was measuring.
- R5: The list index advances by one per result and wraps to 0 after entry `list_len_i`-1. A length of 0 acts as 1 and a length above 8 acts as 8. If the current index is at or beyond the last valid entry, the next index is 0.
- R6: `sclk_o` idles low and has a period of 2*SCLK_HALF system clocks. `din_o` changes only as `sclk_o` rises, and `dout_i` is sampled as `sclk_o` falls.
- R7: At least GAP_SCLK serial-clock periods with `sclk_o` low separate the end of the selector write from the synchronise command, the synchronise from the wake-up, and the wake-up from the read-data command.
- R8: After the read-data command, at least RDW_SCLK serial-clock periods pass before the first result clock edge.
- R9: A fall of `drdy_n_i` while a frame is open is ignored. It starts no extra frame and yields no extra result.
- R10: During reset `cs_n_o` is high, `sclk_o` is low and `res_valid_o` is low.
- R11: After reset, list index 0 is taken as the input being measured, so the first result is tagged 0 and the first selector write uses entry 1 (or entry 0 when the length is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_len_i | input | 4 | Number of list entries in use |
| list_tbl_i | input | 64 | Selector bytes; entry k at bits 8k+7..8k |
| drdy_n_i | input | 1 | Converter data-ready, active low |
| dout_i | input | 1 | Serial data from converter |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data to converter |
| cs_n_o | output | 1 | Chip select, active low |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 24 | Conversion result |
| res_tag_o | output | 3 | List index the result belongs to |

## Verification
The hardest case to reach from the ports is a data-ready fall that arrives while a frame is already open. A real converter never produces one, so the stimulus waits until chip select is low and then pulses the data-ready line by hand in the middle of the command bytes. A second hard case is a length change that leaves the index past the new end. The bench reaches it by shrinking the list between scans, and it also covers lengths of one and zero. A converter model decodes every frame, checks byte order and gap widths, and returns a value tied to the selector it last latched before the wake-up. A wrong or late selector write therefore shows up as a data mismatch in the scoreboard.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_WR0,
    ST_WR1,
    ST_WR2,
    ST_GAPW,
    ST_SYNC,
    ST_GAPS,
    ST_WAKE,
    ST_GAPK,
    ST_RDC,
    ST_RDW,
    ST_RD
  } scan_st_e;

endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic fall_o
);

  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], async_n_i};
      prev_q <= sync_q[1];
    end
  end

  assign fall_o = prev_q & ~sync_q[1];

endmodule

// File: rtl/scan_delay.sv
module scan_delay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] len_i,
  output logic          done_o
);

  logic          act_q, act_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start_i) begin
      act_d = 1'b1;
      cnt_d = len_i;
    end else if (act_q) begin
      if (cnt_q <= DW'(1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      if (start_i || act_q) cnt_q <= cnt_d;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/scan_shift.sv
module scan_shift #(
  parameter int SCLK_HALF = 2,
  parameter int RX_W      = 24,
  localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1,
  localparam int BW = $clog2(RX_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [7:0]      tx_i,
  input  logic [BW-1:0]   nbits_i,
  input  logic            dout_i,
  output logic            sclk_o,
  output logic            din_o,
  output logic            done_o,
  output logic [RX_W-1:0] rx_o
);

  logic            busy_q, busy_d;
  logic            sclk_q, sclk_d;
  logic            din_q, din_d;
  logic            done_q, done_d;
  logic [HW-1:0]   hcnt_q, hcnt_d;
  logic [BW-1:0]   left_q, left_d;
  logic [7:0]      sh_q, sh_d;
  logic [RX_W-1:0] rx_q, rx_d;

  localparam logic [HW-1:0] HRELOAD = HW'(SCLK_HALF - 1);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    din_d  = din_q;
    hcnt_d = hcnt_q;
    left_d = left_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      sclk_d = 1'b1;
      din_d  = tx_i[7];
      sh_d   = {tx_i[6:0], 1'b0};
      left_d = nbits_i;
      hcnt_d = HRELOAD;
      rx_d   = '0;
    end else if (busy_q) begin
      if (hcnt_q != '0) begin
        hcnt_d = hcnt_q - 1'b1;
      end else if (sclk_q) begin
        sclk_d = 1'b0;
        rx_d   = {rx_q[RX_W-2:0], dout_i};
        left_d = left_q - 1'b1;
        hcnt_d = HRELOAD;
      end else if (left_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        sclk_d = 1'b1;
        din_d  = sh_q[7];
        sh_d   = {sh_q[6:0], 1'b0};
        hcnt_d = HRELOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      din_q  <= 1'b0;
      done_q <= 1'b0;
      hcnt_q <= '0;
      left_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= done_d;
      busy_q <= busy_d;
      if (start_i || busy_q) begin
        sclk_q <= sclk_d;
        din_q  <= din_d;
        hcnt_q <= hcnt_d;
        left_q <= left_d;
        sh_q   <= sh_d;
        rx_q   <= rx_d;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign din_o  = din_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/scan_list_ptr.sv
module scan_list_ptr #(
  parameter int N_CH = 8,
  localparam int LEN_W = $clog2(N_CH + 1),
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] cur_o,
  output logic [IDX_W-1:0] nxt_o
);

  logic [IDX_W-1:0] cur_q;
  logic [LEN_W-1:0] last;

  always_comb begin
    if (len_i == '0)                  last = '0;
    else if (len_i > LEN_W'(N_CH))    last = LEN_W'(N_CH - 1);
    else                              last = len_i - 1'b1;
    if (LEN_W'(cur_q) >= last) nxt_o = '0;
    else                       nxt_o = cur_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur_q <= '0;
    else if (adv_i) cur_q <= nxt_o;
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int          N_CH      = 8,
  parameter int          SCLK_HALF = 2,
  parameter int          GAP_SCLK  = 4,
  parameter int          RDW_SCLK  = 8,
  parameter int          RES_W     = 24,
  parameter logic [3:0]  MUX_ADDR  = 4'h1,
  parameter logic [7:0]  OP_WREG   = 8'h50,
  parameter logic [7:0]  OP_SYNC   = 8'hFC,
  parameter logic [7:0]  OP_WAKE   = 8'h00,
  parameter logic [7:0]  OP_RDATA  = 8'h01,
  localparam int LEN_W = $clog2(N_CH + 1),
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  list_len_i,
  input  logic [N_CH*8-1:0] list_tbl_i,
  input  logic              drdy_n_i,
  input  logic              dout_i,
  output logic              sclk_o,
  output logic              din_o,
  output logic              cs_n_o,
  output logic              res_valid_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic [IDX_W-1:0]  res_tag_o
);

  localparam int SCLK_PER = 2 * SCLK_HALF;
  localparam int LEAD_CYC = SCLK_PER;
  localparam int GAP_CYC  = GAP_SCLK * SCLK_PER;
  localparam int RDW_CYC  = RDW_SCLK * SCLK_PER;
  localparam int DLY_MAX  = (GAP_CYC > RDW_CYC) ? GAP_CYC : RDW_CYC;
  localparam int DW       = $clog2(DLY_MAX + 1);
  localparam int BW       = $clog2(RES_W + 1);
  localparam logic [7:0] WR_HDR = OP_WREG | {4'h0, MUX_ADDR};
  localparam logic [7:0] WR_CNT = 8'h00;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  scan_st_e         st_q, st_d;
  logic             drdy_fall;
  logic             eng_start, eng_done;
  logic [7:0]       eng_tx;
  logic [BW-1:0]    eng_nbits;
  logic [RES_W-1:0] eng_rx;
  logic             dly_start, dly_done;
  logic [DW-1:0]    dly_len;
  logic             cap;
  logic [IDX_W-1:0] cur_idx, nxt_idx;
  logic [7:0]       mux_nxt;
  logic             cs_n_q;
  logic             val_q;
  logic [RES_W-1:0] data_q;
  logic [IDX_W-1:0] tag_q;

  scan_edge_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .async_n_i (drdy_n_i),
    .fall_o    (drdy_fall)
  );

  scan_shift #(.SCLK_HALF(SCLK_HALF), .RX_W(RES_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start_i (eng_start),
    .tx_i    (eng_tx),
    .nbits_i (eng_nbits),
    .dout_i  (dout_i),
    .sclk_o  (sclk_o),
    .din_o   (din_o),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  scan_delay #(.DW(DW)) u_delay (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start_i (dly_start),
    .len_i   (dly_len),
    .done_o  (dly_done)
  );

  scan_list_ptr #(.N_CH(N_CH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_s_n),
    .adv_i (cap),
    .len_i (list_len_i),
    .cur_o (cur_idx),
    .nxt_o (nxt_idx)
  );

  assign mux_nxt = list_tbl_i[nxt_idx*8 +: 8];

  always_comb begin
    st_d      = st_q;
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    eng_nbits = BW'(8);
    dly_start = 1'b0;
    dly_len   = DW'(GAP_CYC);
    cap       = 1'b0;
    unique case (st_q)
      ST_IDLE: if (drdy_fall) begin
        st_d = ST_LEAD; dly_start = 1'b1; dly_len = DW'(LEAD_CYC);
      end
      ST_LEAD: if (dly_done) begin
        st_d = ST_WR0; eng_start = 1'b1; eng_tx = WR_HDR;
      end
      ST_WR0: if (eng_done) begin
        st_d = ST_WR1; eng_start = 1'b1; eng_tx = WR_CNT;
      end
      ST_WR1: if (eng_done) begin
        st_d = ST_WR2; eng_start = 1'b1; eng_tx = mux_nxt;
      end
      ST_WR2: if (eng_done) begin
        st_d = ST_GAPW; dly_start = 1'b1;
      end
      ST_GAPW: if (dly_done) begin
        st_d = ST_SYNC; eng_start = 1'b1; eng_tx = OP_SYNC;
      end
      ST_SYNC: if (eng_done) begin
        st_d = ST_GAPS; dly_start = 1'b1;
      end
      ST_GAPS: if (dly_done) begin
        st_d = ST_WAKE; eng_start = 1'b1; eng_tx = OP_WAKE;
      end
      ST_WAKE: if (eng_done) begin
        st_d = ST_GAPK; dly_start = 1'b1;
      end
      ST_GAPK: if (dly_done) begin
        st_d = ST_RDC; eng_start = 1'b1; eng_tx = OP_RDATA;
      end
      ST_RDC: if (eng_done) begin
        st_d = ST_RDW; dly_start = 1'b1; dly_len = DW'(RDW_CYC);
      end
      ST_RDW: if (dly_done) begin
        st_d = ST_RD; eng_start = 1'b1; eng_nbits = BW'(RES_W);
      end
      ST_RD: if (eng_done) begin
        st_d = ST_IDLE; cap = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
      val_q  <= 1'b0;
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= (st_d == ST_IDLE);
      val_q  <= cap;
      if (cap) begin
        data_q <= eng_rx;
        tag_q  <= cur_idx;
      end
    end
  end

  assign cs_n_o      = cs_n_q;
  assign res_valid_o = val_q;
  assign res_data_o  = data_q;
  assign res_tag_o   = tag_q;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
  import adc_scan_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     cs_n,
  input logic     sclk,
  input logic     din,
  input logic     res_valid,
  input scan_st_e st
);

  // R6: serial clock parked low whenever the frame is closed
  p_sclk_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R6: data to converter held steady through the high phase
  p_din_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(din));

  // R1: result strobe lasts one cycle
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R1: strobe coincides with frame close
  p_valid_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && $past(!cs_n)));

  // R7: no clocking inside command gaps
  p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAPS || st == ST_GAPK || st == ST_GAPW) |-> !sclk);

  // R8: no clocking while waiting for result
  p_rdwait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDW) |-> !sclk);

endmodule

bind adc_scan_seq adc_scan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n_o),
  .sclk      (sclk_o),
  .din       (din_o),
  .res_valid (res_valid_o),
  .st        (st_q)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  localparam int PER = 4;
  localparam int GAP = 4;
  localparam int RDW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  len;
  logic [63:0] tbl;
  logic        drdy_n;
  logic        dout;
  logic        sclk_o, din_o, cs_n_o, res_valid_o;
  logic [23:0] res_data_o;
  logic [2:0]  res_tag_o;

  always #10 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .list_len_i(len), .list_tbl_i(tbl),
    .drdy_n_i(drdy_n), .dout_i(dout), .sclk_o(sclk_o), .din_o(din_o),
    .cs_n_o(cs_n_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_tag_o(res_tag_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int n_res = 0;
  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] conv_val(input logic [7:0] m, input int ev);
    return {m, 8'h3C ^ 8'(ev), ~m};
  endfunction

  function automatic logic [7:0] entry(input int k);
    return tbl[k*8 +: 8];
  endfunction

  function automatic int next_idx(input int cur, input int l);
    int last;
    last = (l == 0) ? 0 : ((l > 8) ? 7 : l - 1);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  typedef struct { int tag; logic [23:0] data; } item_t;
  item_t q[$];

  // converter model
  logic [7:0]  m_mux, m_conv, exp_wr, shreg;
  logic [23:0] m_word;
  int bitn, bytei, rd_fall, rd_rise, last_fall, last_rise, m_frames;
  bit rd_ph, live;

  function automatic logic [7:0] exp_byte(input int k);
    case (k)
      0: return 8'h51;
      1: return 8'h00;
      2: return exp_wr;
      3: return 8'hFC;
      4: return 8'h00;
      default: return 8'h01;
    endcase
  endfunction

  always @(negedge cs_n_o) if (live) begin
    m_frames++; bitn = 0; bytei = 0; rd_ph = 0; rd_fall = 0; rd_rise = 0;
  end

  always @(posedge cs_n_o) if (live) begin
    chk(bytei == 6 && rd_fall == 24, "R1", "frame bytes/bits", bytei*100 + rd_fall, 624);
    dout = 1'b0;
  end

  always @(posedge sclk_o) if (live && !cs_n_o) begin
    if (rd_ph) begin
      if (rd_rise == 0)
        chk(cyc - last_fall >= RDW*PER, "R8", "read wait", cyc - last_fall, RDW*PER);
      if (rd_rise < 24) dout = m_word[23 - rd_rise];
      rd_rise++;
    end else begin
      if (bitn == 0 && (bytei == 3 || bytei == 4 || bytei == 5))
        chk(cyc - last_fall >= GAP*PER, "R7", "command gap", cyc - last_fall, GAP*PER);
      if (bitn == 1)
        chk(cyc - last_rise == PER, "R6", "sclk period", cyc - last_rise, PER);
    end
    last_rise = cyc;
  end

  always @(negedge sclk_o) if (live && !cs_n_o) begin
    if (rd_ph) begin
      rd_fall++;
      if (rd_fall == 24) rd_ph = 0;
      last_fall = cyc;
    end else begin
      shreg = {shreg[6:0], din_o};
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        chk(shreg == exp_byte(bytei), (bytei == 2) ? "R3" : "R2", "command byte",
            shreg, exp_byte(bytei));
        if (bytei == 2) m_mux = shreg;
        if (bytei == 4) m_conv = m_mux;
        if (bytei == 5) begin rd_ph = 1; rd_fall = 0; rd_rise = 0; end
        bytei++;
        last_fall = cyc;
      end
    end
  end

  // monitor
  always @(negedge clk) if (live && res_valid_o) begin
    item_t it;
    n_res++;
    if (q.size() == 0) begin
      chk(0, "R9", "unexpected result", n_res, 0);
    end else begin
      it = q.pop_front();
      chk(res_tag_o == 3'(it.tag), "R4", "result tag", res_tag_o, it.tag);
      chk(res_data_o == it.data, "R4", "result data", res_data_o, it.data);
    end
  end

  int exp_idx = 0;
  int ev = 0;

  task automatic scan_event(input bit glitch);
    item_t it;
    int nx;
    it.tag  = exp_idx;
    it.data = conv_val(entry(exp_idx), ev);
    q.push_back(it);
    nx     = next_idx(exp_idx, int'(len));
    exp_wr = entry(nx);
    m_word = conv_val(m_conv, ev);
    @(posedge clk); drdy_n <= 1'b0;
    repeat (3) @(posedge clk); drdy_n <= 1'b1;
    if (glitch) begin
      wait (cs_n_o == 1'b0);
      repeat (60) @(posedge clk); drdy_n <= 1'b0;
      repeat (3) @(posedge clk); drdy_n <= 1'b1;
    end
    wait (n_res == ev + 1);
    repeat (6) @(posedge clk);
    exp_idx = nx;
    ev++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run timed out", cyc, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    live = 0; rst_n = 1'b0; drdy_n = 1'b1; dout = 1'b0; len = 4'd3;
    for (int i = 0; i < 8; i++) tbl[i*8 +: 8] = 8'((i << 4) | ((i + 1) & 15));
    m_frames = 0; bitn = 0; bytei = 0; rd_ph = 0; last_fall = 0; last_rise = 0;
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R10", "cs_n in reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R10", "sclk in reset", sclk_o, 0);
    chk(res_valid_o == 1'b0, "R10", "valid in reset", res_valid_o, 0);
    m_conv = entry(0);  // R11: converter starts on entry 0
    m_mux  = entry(0);
    live   = 1;
    @(posedge clk); rst_n <= 1'b1;
    repeat (5) @(posedge clk);
    // R5 wrap with three entries; first result checks R11
    for (int i = 0; i < 7; i++) scan_event(0);
    len = 4'd8;
    for (int i = 0; i < 10; i++) scan_event(0);
    len = 4'd1;   // index beyond new end wraps to 0
    for (int i = 0; i < 3; i++) scan_event(0);
    len = 4'd0;   // zero acts as one
    for (int i = 0; i < 2; i++) scan_event(0);
    len = 4'd5;
    for (int i = 0; i < 3; i++) scan_event(1);  // R9 mid-frame pulses
    len = 4'd15;  // above eight acts as eight
    for (int i = 0; i < 9; i++) scan_event(0);
    repeat (800) @(negedge clk);
    chk(m_frames == ev, "R9", "frame count", m_frames, ev);
    chk(n_res == ev, "R1", "result count", n_res, ev);
    chk(cs_n_o == 1'b1, "R9", "link idle after ignored pulse", cs_n_o, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule